// File: doc/BRIEF.md
# I2C Bit-Level Primitive Engine

This block performs one indivisible I2C bus action per command: a START, a STOP, the transfer of one data bit in either direction, or the transfer of one acknowledge bit in either direction. A byte-level sequencer above it issues a command with a data bit. The engine then works the two open-drain lines through a fixed series of quarter-period phases. When the action is complete it pulses `done`. It also returns the bit it read from the bus and a sticky flag that reports lost arbitration.

Each bit cell has a low part of two quarter-periods, during which SDA settles, and a high part of two quarter-periods. The engine only ever pulls a line low or lets it go. It reads both lines back through a small synchronizer. All handling of slave clock stretching sits in the one phase where SCL has just been released, and so does the check for lost arbitration. In that phase the phase timer is frozen while the read-back SCL is low. The same phase samples SDA for receive commands and compares it with the sent bit for send commands.

Top module: `i2c_bit_engine`

## Requirements
- R1: After a synchronous active-low reset, both line pulls are released, `cmd_ready` is 1, and `done`, `rx_bit` and `arb_lost` are 0.
- R2: The engine accepts a command only on a rising edge where `cmd_ready` is 1 and `cmd_valid` is 1. While it is busy, `cmd_ready` is 0 and `cmd_valid` has no effect. `done` is high for exactly one cycle, in the cycle the engine returns to idle.
- R3: The quarter period is QDIV = CLK_FREQ/(4*I2C_FREQ) clock cycles. If no slave stretches SCL, a bit or acknowledge command accepted at rising edge E raises `done` after edge E+4*QDIV+SYNC_STAGES.
- R4: After the engine releases SCL, it makes no progress while the read-back SCL is low. Count as edge 1 the first rising edge that samples SCL high. `done` for a bit command then follows edge 3*QDIV+SYNC_STAGES.
- R5: Receive-bit (code 3) and receive-ack (code 5) release SDA. They load `rx_bit` with the SDA level read while SCL is high. No other command changes `rx_bit`.
- R6: Send-bit (code 2) and send-ack (code 4) pull SDA low during the SCL high time exactly when `cmd_bit` is 0.
- R7: A send command with `cmd_bit` = 1 that reads SDA low while SCL is high sets `arb_lost`. The flag then stays set through later commands until the next START.
- R8: START (code 0) clears `arb_lost` when it is accepted. It pulls SDA low while SCL is high and finishes with both lines pulled low.
- R9: STOP (code 1) pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is high. It finishes with both lines released.
- R10: Outside the START and STOP edges, the engine changes its SDA pull only while SCL is low.
- R11: Codes 6 and 7 are not accepted. `cmd_ready` stays 1, no `done` follows, and both line pulls are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code: 0 START, 1 STOP, 2 send bit, 3 receive bit, 4 send ack, 5 receive ack |
| cmd_bit | input | 1 | Bit to send for codes 2 and 4 |
| cmd_ready | output | 1 | Engine idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Last bit received |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| scl_in | input | 1 | SCL level read from the bus |
| sda_in | input | 1 | SDA level read from the bus |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two situations are hard to reach from the ports. The first is a slave that holds SCL low after the engine has released it. The bench produces this with its own stretch driver on the wired-AND bus model, keeps the line low for many quarter periods, and then counts the edges from the release of the stretch to `done`. The second is a lost bit. A bench-side slave pulls SDA low during a send of 1, the bench checks that the flag persists through later conflict-free commands, and then it checks that a repeated START clears it. Random sequences of bit and acknowledge commands, with random slave responses, cover the other cases.

// File: rtl/i2c_bit_pkg.sv
`timescale 1ns/1ps
// Shared command codes and phase encoding for the I2C bit engine.
// Assumes the command field is three bits wide; codes 6 and 7 are unused.
package i2c_bit_pkg;

    typedef enum logic [2:0] {
        OP_START    = 3'd0,
        OP_STOP     = 3'd1,
        OP_SEND_BIT = 3'd2,
        OP_RECV_BIT = 3'd3,
        OP_SEND_ACK = 3'd4,
        OP_RECV_ACK = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_SETUP    = 3'd1,
        PH_HIGH     = 3'd2,
        PH_HOLD     = 3'd3,
        PH_LOW      = 3'd4,
        PH_STA_EDGE = 3'd5,
        PH_STO_EDGE = 3'd6
    } phase_e;

    // True for the six defined command codes.
    function automatic logic op_is_valid(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    // True for commands that read SDA during the high phase.
    function automatic logic op_is_recv(input op_e op);
        return (op == OP_RECV_BIT) || (op == OP_RECV_ACK);
    endfunction

    // True for commands that place a bit on SDA.
    function automatic logic op_is_send(input op_e op);
        return (op == OP_SEND_BIT) || (op == OP_SEND_ACK);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one bus line read-back.
// Assumes STAGES >= 1; resets to the released (high) level.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= line_in;
            end
        end else begin : g_multi
            // Shift chain of capture flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_s = chain[STAGES-1];

endmodule

// File: rtl/i2c_qtick_div.sv
`timescale 1ns/1ps
// Quarter-period tick divider. Emits one tick every QDIV counted cycles.
// clr forces the count to zero; hold freezes it (used while SCL is stretched).
// Assumes QDIV >= 2.
module i2c_qtick_div #(
    parameter int QDIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hold,
    output logic tick
);

    localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    assign tick = !clr && !hold && (cnt == LAST);

    // Count cycles within the current quarter period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (hold)     cnt <= cnt;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !clr |=> $stable(cnt));

endmodule

// File: rtl/i2c_bit_capture.sv
`timescale 1ns/1ps
// Receive-bit register and sticky arbitration-loss flag.
// Assumes sample_en and arb_check_en are single-cycle strobes raised at the
// end of the confirmed SCL-high quarter.
module i2c_bit_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic arb_check_en,
    input  logic tx_bit,
    input  logic sda_s,
    input  logic clr_arb,
    output logic rx_bit,
    output logic arb_lost
);

    // Latch the received SDA level.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_bit <= 1'b0;
        else if (sample_en) rx_bit <= sda_s;
    end

    // Set the flag when a released SDA reads back low; clear on START.
    always_ff @(posedge clk) begin
        if (!rst_n)                                arb_lost <= 1'b0;
        else if (clr_arb)                          arb_lost <= 1'b0;
        else if (arb_check_en && tx_bit && !sda_s) arb_lost <= 1'b1;
    end

    p_rx_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(rx_bit));

    p_arb_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost && !clr_arb |=> arb_lost);

    p_arb_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_arb |=> !arb_lost);

endmodule

// File: rtl/i2c_phase_seq.sv
`timescale 1ns/1ps
// Phase sequencer: walks one primitive through its quarter-period phases and
// owns the registered open-drain pull controls. The only SCL-high wait with
// stretch handling is PH_HIGH; sample and arbitration strobes come from there.
// Assumes tick pulses once per quarter period and scl_s is synchronized.
module i2c_phase_seq
    import i2c_bit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       cmd_bit,
    input  logic       tick,
    input  logic       scl_s,
    output logic       ready,
    output logic       done,
    output logic       clr_timer,
    output logic       hold_timer,
    output logic       scl_low,
    output logic       sda_low,
    output logic       sample_en,
    output logic       arb_check_en,
    output logic       clr_arb,
    output logic       tx_bit
);

    phase_e phase, phase_nx;
    op_e    op_r, op_nx;
    logic   bit_r, bit_nx;
    logic   scl_low_r, sda_low_r;
    logic   done_r;
    logic   accept;
    logic   hi_done;
    logic   setup_sda_low;

    assign accept     = (phase == PH_IDLE) && cmd_valid && op_is_valid(cmd_op);
    assign clr_timer  = (phase == PH_IDLE);
    assign hold_timer = (phase == PH_HIGH) && !scl_s;
    assign hi_done    = (phase == PH_HIGH) && tick && scl_s;

    assign op_nx  = accept ? op_e'(cmd_op) : op_r;
    assign bit_nx = accept ? cmd_bit : bit_r;

    // SDA level chosen for the low part of the cell.
    always_comb begin
        if (op_nx == OP_STOP)         setup_sda_low = 1'b1;
        else if (op_is_send(op_nx))   setup_sda_low = !bit_nx;
        else                          setup_sda_low = 1'b0;
    end

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:     if (accept) phase_nx = PH_SETUP;
            PH_SETUP:    if (tick)   phase_nx = PH_HIGH;
            PH_HIGH: begin
                if (hi_done) begin
                    if (op_r == OP_START)     phase_nx = PH_STA_EDGE;
                    else if (op_r == OP_STOP) phase_nx = PH_STO_EDGE;
                    else                      phase_nx = PH_HOLD;
                end
            end
            PH_HOLD:     if (tick)   phase_nx = PH_LOW;
            PH_STA_EDGE: if (tick)   phase_nx = PH_LOW;
            PH_LOW:      if (tick)   phase_nx = PH_IDLE;
            PH_STO_EDGE: if (tick)   phase_nx = PH_IDLE;
            default:                 phase_nx = PH_IDLE;
        endcase
    end

    // Phase register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            done_r <= 1'b0;
        end else begin
            phase  <= phase_nx;
            done_r <= (phase != PH_IDLE) && (phase_nx == PH_IDLE);
        end
    end

    // Latch command and data bit on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_r  <= OP_START;
            bit_r <= 1'b1;
        end else if (accept) begin
            op_r  <= op_e'(cmd_op);
            bit_r <= cmd_bit;
        end
    end

    // Registered line pulls, set for the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_low_r <= 1'b0;
            sda_low_r <= 1'b0;
        end else begin
            case (phase_nx)
                PH_SETUP: begin
                    if (op_nx == OP_START) begin
                        sda_low_r <= 1'b0;
                    end else begin
                        scl_low_r <= 1'b1;
                        if (scl_low_r) sda_low_r <= setup_sda_low;
                    end
                end
                PH_HIGH:     scl_low_r <= 1'b0;
                PH_STA_EDGE: sda_low_r <= 1'b1;
                PH_STO_EDGE: sda_low_r <= 1'b0;
                PH_LOW:      scl_low_r <= 1'b1;
                default: ;
            endcase
        end
    end

    assign ready        = (phase == PH_IDLE);
    assign done         = done_r;
    assign scl_low      = scl_low_r;
    assign sda_low      = sda_low_r;
    assign sample_en    = hi_done && op_is_recv(op_r);
    assign arb_check_en = hi_done && op_is_send(op_r);
    assign clr_arb      = accept && (cmd_op == 3'(OP_START));
    assign tx_bit       = bit_r;

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cmd_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) && ($past(phase) != PH_IDLE) |-> $stable(op_r) && $stable(bit_r));

    p_stretch_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH) && !scl_s |=> (phase == PH_HIGH));

    p_sda_when_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_r) && (phase != PH_STA_EDGE) && (phase != PH_STO_EDGE)
            |-> scl_low_r && $past(scl_low_r));

    p_start_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_r) && !$past(scl_low_r) |-> (phase == PH_STA_EDGE));

endmodule

// File: rtl/i2c_bit_engine.sv
`timescale 1ns/1ps
// I2C bit-level primitive engine top. Divides the system clock into quarter
// periods, synchronizes the bus read-back, sequences one primitive at a time
// and captures the received bit and arbitration loss.
// Assumes CLK_FREQ >= 8*I2C_FREQ (at least two cycles per quarter) and
// external pull-ups on both lines.
module i2c_bit_engine #(
    parameter int CLK_FREQ    = 50_000_000,
    parameter int I2C_FREQ    = 100_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       cmd_bit,
    output logic       cmd_ready,
    output logic       done,
    output logic       rx_bit,
    output logic       arb_lost,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull
);

    localparam int QDIV = CLK_FREQ / (4 * I2C_FREQ);

    logic scl_s, sda_s;
    logic tick, clr_timer, hold_timer;
    logic sample_en, arb_check_en, clr_arb, tx_bit;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_s(scl_s)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_s(sda_s)
    );

    i2c_qtick_div #(.QDIV(QDIV)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr_timer), .hold(hold_timer), .tick(tick)
    );

    i2c_phase_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
        .tick(tick), .scl_s(scl_s),
        .ready(cmd_ready), .done(done),
        .clr_timer(clr_timer), .hold_timer(hold_timer),
        .scl_low(scl_pull), .sda_low(sda_pull),
        .sample_en(sample_en), .arb_check_en(arb_check_en),
        .clr_arb(clr_arb), .tx_bit(tx_bit)
    );

    i2c_bit_capture u_cap (
        .clk(clk), .rst_n(rst_n),
        .sample_en(sample_en), .arb_check_en(arb_check_en),
        .tx_bit(tx_bit), .sda_s(sda_s), .clr_arb(clr_arb),
        .rx_bit(rx_bit), .arb_lost(arb_lost)
    );

    p_done_in_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    p_busy_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && cmd_valid && (cmd_op <= 3'd5) |=> !cmd_ready);

    p_bad_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && cmd_valid && (cmd_op > 3'd5) |=> cmd_ready && $stable(scl_pull) && $stable(sda_pull));

endmodule

// File: tb/tb_i2c_bit_engine.sv
`timescale 1ns/1ps
// Self-checking bench: wired-AND bus model with a stretch driver and a slave
// SDA driver, directed corner cases plus seeded random bit sequences.
module tb_i2c_bit_engine;

    localparam int CLKF = 4_000_000;
    localparam int BUSF = 250_000;
    localparam int SYNC = 2;
    localparam int Q    = CLKF / (4 * BUSF);

    localparam logic [2:0] C_START = 3'd0, C_STOP = 3'd1, C_SBIT = 3'd2,
                           C_RBIT = 3'd3, C_SACK = 3'd4, C_RACK = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic cmd_bit = 1'b0;
    logic cmd_ready, done, rx_bit, arb_lost, scl_pull, sda_pull;
    logic scl_stretch = 1'b0;
    logic slv_low = 1'b0;
    wire  scl_in = !(scl_pull || scl_stretch);
    wire  sda_in = !(sda_pull || slv_low);

    int nchk = 0, nerr = 0, r10_bad = 0;
    bit finished = 1'b0;
    logic [2:0] cur_op = 3'd7;
    bit sta_edge_seen = 1'b0, sto_edge_seen = 1'b0;
    logic sda_at_rise = 1'b1;
    bit exp_rx = 1'b0, exp_arb = 1'b0;

    always #2.5 clk = !clk;

    i2c_bit_engine #(.CLK_FREQ(CLKF), .I2C_FREQ(BUSF), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .cmd_ready(cmd_ready), .done(done), .rx_bit(rx_bit),
        .arb_lost(arb_lost), .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    // Bus SDA level at each SCL rising edge on the wire.
    always @(posedge scl_in) sda_at_rise = sda_in;

    // R10 monitor: SDA pull may change with SCL high only at START/STOP edges.
    always @(sda_pull) begin
        if (rst_n === 1'b1 && scl_in === 1'b1) begin
            if (cur_op == C_START && sda_pull === 1'b1)     sta_edge_seen = 1'b1;
            else if (cur_op == C_STOP && sda_pull === 1'b0) sto_edge_seen = 1'b1;
            else r10_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    // Expected-value models.
    function automatic bit model_rx(bit cur, logic [2:0] op, bit slave_low);
        if (op == C_RBIT || op == C_RACK) return !slave_low;
        return cur;
    endfunction

    function automatic bit model_arb(bit cur, logic [2:0] op, bit b, bit slave_low);
        if (op == C_START) return 1'b0;
        if ((op == C_SBIT || op == C_SACK) && b && slave_low) return 1'b1;
        return cur;
    endfunction

    // Issue one command and count edges from acceptance to done.
    task automatic run_cmd(input logic [2:0] op, input bit b, output int n);
        @(negedge clk);
        cur_op = op;
        cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
        @(posedge clk);
        n = 1;
        #1 cmd_valid = 1'b0;
        while (!done && n < 4000) begin
            @(posedge clk); n++; #1;
        end
    endtask

    task automatic do_start();
        int n;
        sta_edge_seen = 1'b0;
        run_cmd(C_START, 1'b0, n);
        exp_arb = 1'b0;
        chk(sta_edge_seen, "R8 start edge", sta_edge_seen, 1);
        chk(scl_pull && sda_pull, "R8 start end lines", {scl_pull, sda_pull}, 3);
        chk(arb_lost == 1'b0, "R8 arb cleared", arb_lost, 0);
    endtask

    task automatic do_bit(input logic [2:0] op, input bit b, input bit slave_low);
        int n;
        @(negedge clk); slv_low = slave_low;
        run_cmd(op, b, n);
        exp_rx  = model_rx(exp_rx, op, slave_low);
        exp_arb = model_arb(exp_arb, op, b, slave_low);
        chk(n == 4*Q + SYNC + 1, "R3 bit duration", n, 4*Q + SYNC + 1);
        chk(rx_bit == exp_rx, "R5 rx_bit", rx_bit, exp_rx);
        chk(arb_lost == exp_arb, "R7 arb_lost", arb_lost, exp_arb);
        if (op == C_SBIT || op == C_SACK)
            chk(sda_at_rise == (b && !slave_low), "R6 sda during high", sda_at_rise, b && !slave_low);
        @(negedge clk); slv_low = 1'b0;
    endtask

    task automatic do_stop();
        int n;
        sto_edge_seen = 1'b0;
        run_cmd(C_STOP, 1'b0, n);
        chk(sto_edge_seen, "R9 stop edge", sto_edge_seen, 1);
        chk(!scl_pull && !sda_pull, "R9 stop end lines", {scl_pull, sda_pull}, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int dn;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!scl_pull && !sda_pull, "R1 lines released", {scl_pull, sda_pull}, 0);
        chk(cmd_ready && !done, "R1 ready/done", {cmd_ready, done}, 2);
        chk(!arb_lost && !rx_bit, "R1 flags", {arb_lost, rx_bit}, 0);

        // R11 invalid codes ignored
        for (int c = 6; c < 8; c++) begin
            @(negedge clk); cur_op = 3'(c); cmd_op = 3'(c); cmd_valid = 1'b1;
            dn = 0;
            repeat (3*Q) begin
                @(posedge clk); #1;
                if (done || !cmd_ready || scl_pull || sda_pull) dn++;
            end
            cmd_valid = 1'b0;
            chk(dn == 0, "R11 invalid code ignored", dn, 0);
        end

        do_start();
        do_bit(C_SBIT, 1'b1, 1'b0);
        do_bit(C_SBIT, 1'b0, 1'b0);
        do_bit(C_RBIT, 1'b0, 1'b0);
        do_bit(C_RACK, 1'b0, 1'b1);
        do_bit(C_SACK, 1'b0, 1'b0);
        // R5: send leaves rx_bit alone after a receive of 1
        do_bit(C_RBIT, 1'b0, 1'b0);
        do_bit(C_SBIT, 1'b0, 1'b0);
        chk(rx_bit == 1'b1, "R5 send keeps rx_bit", rx_bit, 1);

        // R4 stretch: slave holds SCL low well past the release
        @(negedge clk); scl_stretch = 1'b1; cur_op = C_SBIT;
        cmd_op = C_SBIT; cmd_bit = 1'b1; cmd_valid = 1'b1;
        @(posedge clk); #1 cmd_valid = 1'b0;
        dn = 0;
        repeat (10*Q) begin @(posedge clk); #1; if (done) dn++; end
        chk(dn == 0, "R4 no done while stretched", dn, 0);
        chk(scl_pull == 1'b0, "R4 engine released SCL", scl_pull, 0);
        @(negedge clk); scl_stretch = 1'b0;
        n = 0;
        while (!done && n < 4000) begin @(posedge clk); n++; #1; end
        chk(n == 3*Q + SYNC, "R4 done after stretch release", n, 3*Q + SYNC);

        // R7 arbitration loss and stickiness, R8 clear by repeated START
        do_bit(C_SBIT, 1'b1, 1'b1);
        do_bit(C_SBIT, 1'b0, 1'b0);
        do_bit(C_RBIT, 1'b0, 1'b0);
        chk(arb_lost == 1'b1, "R7 flag sticky", arb_lost, 1);
        do_bit(C_SACK, 1'b1, 1'b1);
        do_start();

        // R2 busy: a new request during a receive is ignored
        @(negedge clk); cur_op = C_RBIT; cmd_op = C_RBIT; cmd_bit = 1'b0; cmd_valid = 1'b1;
        @(posedge clk); #1 cmd_valid = 1'b0;
        chk(!cmd_ready, "R2 busy not ready", cmd_ready, 0);
        @(negedge clk); cmd_op = C_STOP; cmd_valid = 1'b1;
        repeat (Q) @(negedge clk);
        cmd_valid = 1'b0;
        n = 0; dn = 0;
        while (n < 8*Q) begin
            @(posedge clk); n++; #1;
            if (done) dn++;
        end
        chk(dn == 1, "R2 single done pulse", dn, 1);
        chk(cmd_ready && scl_pull, "R2 busy request dropped", {cmd_ready, scl_pull}, 3);
        exp_rx = 1'b1;

        // Random sequences
        for (int it = 0; it < 30; it++) begin
            int nb;
            nb = $urandom_range(2, 9);
            for (int k = 0; k < nb; k++) begin
                logic [2:0] op;
                bit b, sl;
                op = 3'($urandom_range(2, 5));
                b  = 1'($urandom_range(0, 1));
                sl = ($urandom_range(0, 3) == 0);
                do_bit(op, b, sl);
            end
            if ($urandom_range(0, 2) == 0) do_start();
            else begin
                do_stop();
                do_start();
            end
        end
        do_stop();

        chk(r10_bad == 0, "R10 SDA change with SCL high", r10_bad, 0);
        finish_run();
    end

endmodule